// File: doc/BRIEF.md
# I2C Slave Event Flags and Interrupt

This block sits beside an I2C slave byte engine and watches the same bus lines. It follows each transaction bit by bit and raises four sticky event flags: bus STOP seen, START followed by two full SCL clocks, first written data byte captured as a memory pointer, and a transmitted byte whose acknowledge bit has been sampled. Each flag has its own enable bit, and a single level interrupt line goes high while any enabled flag is set.

Software reaches the block through a small register port. It can read the flags, the enables and the captured pointer. It clears a flag by writing 0 to it, and it can set a flag by writing 1, which raises the interrupt in the same way a bus event would. The bus inputs are synchronized inside the block, so SCL and SDA may arrive asynchronously to the system clock. The slave's own 7-bit address is an input.

Top module: `i2c_slv_evt_irq`

## Requirements
- R1: A STOP (SDA rising while SCL is high) sets status bit 0.
- R2: Status bit 1 is set after a START once two complete SCL cycles (a rise and then a fall, twice) have followed it. A START followed by a single cycle and then a STOP leaves bit 1 clear.
- R3: When the address byte matches `own_addr` with R/W bit 0, the next received data byte is loaded into the pointer register (register address 2) at its acknowledge clock, and status bit 2 is set.
- R4: A match with R/W bit 1 does not load the pointer. Data bytes after the first one in a write transaction leave the pointer unchanged.
- R5: A repeated START re-arms pointer capture, so a write-matched transaction that follows it loads its first data byte.
- R6: In a read-matched transaction, status bit 3 is set when the acknowledge clock of a transmitted byte rises. This happens whether SDA is low (ACK) or high (NACK) at that clock. A NACK ends byte tracking until the next START.
- R7: Flags are sticky. A write to the status register (address 0) loads every flag from the written bits, so writing 0 clears a flag, and a flag that is not cleared stays set.
- R8: Writing 1 to a status bit sets that flag exactly as a bus event does.
- R9: `irq` is high exactly when some status bit and the matching enable bit (register address 1, same bit position) are both 1. With all enables at 0, `irq` stays low.
- R10: Bits 7:4 of the status and enable registers read as 0 whatever is written to them. The pointer register ignores writes. Address 3 reads as 0.
- R11: When a bus event and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R12: An address byte that does not match `own_addr` loads no pointer and sets neither bit 2 nor bit 3.
- R13: After reset, all flags, enables and the pointer are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| own_addr | input | 7 | Slave address to match |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (0 status, 1 enable, 2 pointer) |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from `rd_addr` |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The transaction tracker is driven with random transactions. Each one picks matching or foreign addresses, either direction, zero to three data bytes and random ACK/NACK bits. These separate capture on a write match from the read and mismatch cases, and the first data byte from later ones. Directed sequences add a repeated START between two write addresses to show re-arming, and a START with a single clock to show the two-cycle threshold. A software clear is timed onto the exact cycle of a bus event to show that the hardware set wins. Register pokes at the reserved bits and the read-only pointer separate real storage from hard zeros.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
    localparam int NFLAG    = 4;
    localparam int BYTE_W   = 8;
    localparam int RA_W     = 2;

    localparam int FLG_STOP = 0;
    localparam int FLG_AFST = 1;
    localparam int FLG_MEMA = 2;
    localparam int FLG_TXDN = 3;

    localparam logic [RA_W-1:0] RA_STAT = 2'd0;
    localparam logic [RA_W-1:0] RA_EN   = 2'd1;
    localparam logic [RA_W-1:0] RA_PTR  = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WFIRST,
        PH_WREST,
        PH_RDATA
    } phase_e;
endpackage

// File: rtl/i2c_evt_sync.sv
module i2c_evt_sync #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [DEPTH-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[DEPTH-2:0], async_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_out[i] = chain_q[DEPTH-1];
    end
endmodule

// File: rtl/i2c_evt_bus_mon.sv
module i2c_evt_bus_mon
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int AS_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    output logic [NFLAG-1:0]  evt,
    output logic              ptr_we,
    output logic [BYTE_W-1:0] ptr_val
);
    localparam int AS_W  = $clog2(AS_CYCLES + 1);
    localparam int BC_W  = $clog2(BYTE_W + 1);
    localparam logic [AS_W-1:0] AS_LAST  = AS_W'(AS_CYCLES);
    localparam logic [BC_W-1:0] ACK_SLOT = BC_W'(BYTE_W);

    typedef struct packed {
        logic              scl_p;
        logic              sda_p;
        phase_e            phase;
        logic [BC_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0] shreg;
        logic              as_armed;
        logic [AS_W-1:0]   as_cnt;
        logic [NFLAG-1:0]  evt;
        logic              ptr_we;
        logic [BYTE_W-1:0] ptr_val;
    } mon_t;

    mon_t st_d, st_q;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic addr_hit;

    always_comb begin
        scl_rise  = scl_s & ~st_q.scl_p;
        scl_fall  = ~scl_s & st_q.scl_p;
        bus_start = scl_s & st_q.scl_p & st_q.sda_p & ~sda_s;
        bus_stop  = scl_s & st_q.scl_p & ~st_q.sda_p & sda_s;
        addr_hit  = (st_q.shreg[BYTE_W-1:1] == own_addr);

        st_d         = st_q;
        st_d.scl_p   = scl_s;
        st_d.sda_p   = sda_s;
        st_d.evt     = '0;
        st_d.ptr_we  = 1'b0;

        if (bus_start) begin
            st_d.phase    = PH_ADDR;
            st_d.bit_cnt  = '0;
            st_d.as_armed = 1'b1;
            st_d.as_cnt   = '0;
        end else if (bus_stop) begin
            st_d.evt[FLG_STOP] = 1'b1;
            st_d.phase         = PH_IDLE;
            st_d.bit_cnt       = '0;
            st_d.as_armed      = 1'b0;
        end else begin
            if (st_q.as_armed) begin
                if (scl_rise && st_q.as_cnt != AS_LAST)
                    st_d.as_cnt = st_q.as_cnt + 1'b1;
                if (scl_fall && st_q.as_cnt == AS_LAST) begin
                    st_d.evt[FLG_AFST] = 1'b1;
                    st_d.as_armed      = 1'b0;
                end
            end
            if (scl_rise && st_q.phase != PH_IDLE) begin
                if (st_q.bit_cnt != ACK_SLOT) begin
                    st_d.shreg   = {st_q.shreg[BYTE_W-2:0], sda_s};
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end else begin
                    st_d.bit_cnt = '0;
                    unique case (st_q.phase)
                        PH_ADDR: begin
                            if (!addr_hit)           st_d.phase = PH_IDLE;
                            else if (st_q.shreg[0])  st_d.phase = PH_RDATA;
                            else                     st_d.phase = PH_WFIRST;
                        end
                        PH_WFIRST: begin
                            st_d.ptr_we        = 1'b1;
                            st_d.ptr_val       = st_q.shreg;
                            st_d.evt[FLG_MEMA] = 1'b1;
                            st_d.phase         = PH_WREST;
                        end
                        PH_RDATA: begin
                            st_d.evt[FLG_TXDN] = 1'b1;
                            if (sda_s) st_d.phase = PH_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.scl_p <= 1'b1;
            st_q.sda_p <= 1'b1;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt     = st_q.evt;
    assign ptr_we  = st_q.ptr_we;
    assign ptr_val = st_q.ptr_val;
endmodule

// File: rtl/i2c_evt_regs.sv
module i2c_evt_regs
    import i2c_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  evt,
    input  logic              ptr_we,
    input  logic [BYTE_W-1:0] ptr_val,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [NFLAG-1:0]  flags,
    output logic [NFLAG-1:0]  en,
    output logic [BYTE_W-1:0] ptr,
    output logic              irq
);
    localparam int PAD_W = BYTE_W - NFLAG;

    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic [NFLAG-1:0]  en;
        logic [BYTE_W-1:0] ptr;
    } reg_t;

    reg_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en && wr_addr == RA_STAT) rg_d.flags = wr_data[NFLAG-1:0];
        if (wr_en && wr_addr == RA_EN)   rg_d.en    = wr_data[NFLAG-1:0];
        rg_d.flags = rg_d.flags | evt;
        if (ptr_we) rg_d.ptr = ptr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (rd_addr)
            RA_STAT: rd_data = {{PAD_W{1'b0}}, rg_q.flags};
            RA_EN:   rd_data = {{PAD_W{1'b0}}, rg_q.en};
            RA_PTR:  rd_data = rg_q.ptr;
            default: rd_data = '0;
        endcase
    end

    assign flags = rg_q.flags;
    assign en    = rg_q.en;
    assign ptr   = rg_q.ptr;
    assign irq   = |(rg_q.flags & rg_q.en);
endmodule

// File: rtl/i2c_slv_evt_irq.sv
module i2c_slv_evt_irq
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_DEPTH = 2,
    parameter int AS_CYCLES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [BYTE_W-2:0]   own_addr,
    input  logic                wr_en,
    input  logic [RA_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [RA_W-1:0]     rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                irq
);
    logic [1:0]        bus_s;
    logic [NFLAG-1:0]  evt_w;
    logic              ptr_we_w;
    logic [BYTE_W-1:0] ptr_val_w;
    logic [NFLAG-1:0]  flags_w;
    logic [NFLAG-1:0]  en_w;
    logic [BYTE_W-1:0] ptr_w;

    i2c_evt_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (bus_s)
    );

    i2c_evt_bus_mon #(.ADDR_W(BYTE_W-1), .AS_CYCLES(AS_CYCLES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (bus_s[1]),
        .sda_s    (bus_s[0]),
        .own_addr (own_addr),
        .evt      (evt_w),
        .ptr_we   (ptr_we_w),
        .ptr_val  (ptr_val_w)
    );

    i2c_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_w),
        .ptr_we   (ptr_we_w),
        .ptr_val  (ptr_val_w),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .flags    (flags_w),
        .en       (en_w),
        .ptr      (ptr_w),
        .irq      (irq)
    );
endmodule

// File: rtl/i2c_evt_chk.sv
module i2c_evt_chk
    import i2c_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [RA_W-1:0]   wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [NFLAG-1:0]  evt,
    input logic              ptr_we,
    input logic [BYTE_W-1:0] ptr_val,
    input logic [NFLAG-1:0]  flags,
    input logic [NFLAG-1:0]  en,
    input logic [BYTE_W-1:0] ptr,
    input logic              irq
);
    logic stat_wr;
    assign stat_wr = wr_en && (wr_addr == RA_STAT);

    AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[FLG_STOP] |=> flags[FLG_STOP]); // R1

    AST_MEM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (ptr == $past(ptr_val)) && flags[FLG_MEMA]); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(ptr)); // R4

    AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_TXDN] && !stat_wr) |=> flags[FLG_TXDN]); // R7

    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((flags & $past(wr_data[NFLAG-1:0])) == $past(wr_data[NFLAG-1:0]))); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R9

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[FLG_AFST] && stat_wr && !wr_data[FLG_AFST]) |=> flags[FLG_AFST]); // R11
endmodule

bind i2c_slv_evt_irq i2c_evt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .evt     (evt_w),
    .ptr_we  (ptr_we_w),
    .ptr_val (ptr_val_w),
    .flags   (flags_w),
    .en      (en_w),
    .ptr     (ptr_w),
    .irq     (irq)
);

// File: tb/sim_i2c_slv_evt_irq.sv
module sim_i2c_slv_evt_irq;
    localparam int HALF = 6;
    localparam logic [6:0] OWN = 7'h42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_ptr = 8'd0;

    always #10 clk = ~clk;

    i2c_slv_evt_irq u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .own_addr(OWN),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] e);
        logic [7:0] v;
        reg_rd(a, v);
        check(req, v, e);
    endtask

    task automatic bus_bit(input logic b, input bit clr_at_rise);
        @(negedge clk); sda = b;
        wait_clk(HALF);
        scl = 1'b1;
        if (clr_at_rise) begin
            wait_clk(3);
            wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00;
            @(negedge clk); wr_en = 1'b0;
            wait_clk(HALF - 4);
        end else begin
            wait_clk(HALF);
        end
        scl = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic bus_start();
        @(negedge clk); sda = 1'b1; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda = 1'b0; wait_clk(HALF);
        scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        @(negedge clk); sda = 1'b0; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda = 1'b1; wait_clk(HALF * 2);
    endtask

    task automatic bus_byte(input logic [7:0] v, input logic ack, input bit clr_at_ack);
        for (int i = 7; i >= 0; i--) bus_bit(v[i], 1'b0);
        bus_bit(ack, clr_at_ack);
    endtask

    function automatic logic [7:0] exp_stat(input bit match, input bit rd, input int nb);
        logic [7:0] s;
        s = 8'h03;
        if (match && !rd && nb > 0) s[2] = 1'b1;
        if (match && rd && nb > 0)  s[3] = 1'b1;
        return s;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'h1c2e));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R13 reset state
        chk_reg("R13 status", 2'd0, 8'h00);
        chk_reg("R13 enable", 2'd1, 8'h00);
        chk_reg("R13 pointer", 2'd2, 8'h00);
        check("R13 irq", {7'd0, irq}, 8'h00);

        // R10 reserved bits, read-only pointer, unused address
        reg_wr(2'd1, 8'hFF);
        chk_reg("R10 enable upper bits", 2'd1, 8'h0F);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'hF0);
        chk_reg("R10 status upper bits", 2'd0, 8'h00);
        reg_wr(2'd2, 8'h55);
        chk_reg("R10 pointer write ignored", 2'd2, 8'h00);
        chk_reg("R10 address 3", 2'd3, 8'h00);

        // R8 / R9 software set and masking
        reg_wr(2'd0, 8'h02);
        chk_reg("R8 software set", 2'd0, 8'h02);
        check("R9 masked irq", {7'd0, irq}, 8'h00);
        reg_wr(2'd1, 8'h02);
        check("R9 enabled irq", {7'd0, irq}, 8'h01);
        reg_wr(2'd1, 8'h01);
        check("R9 other enable", {7'd0, irq}, 8'h00);
        reg_wr(2'd0, 8'h00);
        chk_reg("R7 clear by 0", 2'd0, 8'h00);

        // R1 / R9 stop raises irq when enabled; R2 single cycle is not enough
        bus_start();
        bus_bit(1'b1, 1'b0);
        bus_stop();
        chk_reg("R2 one cycle only, R1 stop", 2'd0, 8'h01);
        check("R9 stop irq", {7'd0, irq}, 8'h01);
        wait_clk(40);
        chk_reg("R7 sticky while idle", 2'd0, 8'h01);
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h00);

        // R5 repeated start re-arms; R3 capture; R4 later byte ignored
        bus_start();
        bus_byte({OWN, 1'b0}, 1'b0, 1'b0);
        bus_start();
        bus_byte({OWN, 1'b0}, 1'b0, 1'b0);
        bus_byte(8'hA5, 1'b0, 1'b0);
        bus_byte(8'h3C, 1'b0, 1'b0);
        bus_stop();
        exp_ptr = 8'hA5;
        chk_reg("R5 R3 pointer after repeated start", 2'd2, exp_ptr);
        chk_reg("R3 status", 2'd0, 8'h07);
        reg_wr(2'd0, 8'h03);
        chk_reg("R7 partial clear", 2'd0, 8'h03);
        reg_wr(2'd0, 8'h00);

        // R4 read direction, R6 ACK then NACK
        bus_start();
        bus_byte({OWN, 1'b1}, 1'b0, 1'b0);
        bus_byte(8'h99, 1'b1, 1'b0);
        bus_stop();
        chk_reg("R4 read keeps pointer", 2'd2, exp_ptr);
        chk_reg("R6 tx done on NACK", 2'd0, 8'h0B);
        reg_wr(2'd0, 8'h00);

        // R11 hardware set wins over same-cycle clear
        bus_start();
        bus_byte({OWN, 1'b0}, 1'b0, 1'b0);
        bus_byte(8'h5E, 1'b0, 1'b1);
        exp_ptr = 8'h5E;
        chk_reg("R11 hw set wins", 2'd0, 8'h04);
        bus_stop();
        reg_wr(2'd0, 8'h00);

        // random transactions: R3 R4 R6 R12
        for (int t = 0; t < 40; t++) begin
            bit match, rd;
            int nb;
            logic [6:0] a;
            logic [7:0] first;
            match = ($urandom % 2) == 1;
            rd    = ($urandom % 2) == 1;
            nb    = $urandom % 4;
            a     = match ? OWN : (OWN ^ 7'(($urandom % 127) + 1));
            bus_start();
            bus_byte({a, rd}, 1'b0, 1'b0);
            first = 8'h00;
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (b == 0) first = d;
                bus_byte(d, rd ? logic'($urandom % 2) : 1'b0, 1'b0);
            end
            bus_stop();
            if (match && !rd && nb > 0) exp_ptr = first;
            chk_reg("R12 R3 R4 random pointer", 2'd2, exp_ptr);
            chk_reg("R12 R6 random status", 2'd0, exp_stat(match, rd, nb));
            reg_wr(2'd0, 8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule